// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Load Cache

This block is a direct-mapped data cache for the load path. The line index and the word select come only from the untranslated page-offset bits of the load address. The data and tag arrays can therefore be read in the same cycle that the translation buffer turns the virtual page number into a physical page number. That physical page number arrives on a separate input with its own valid flag. The block compares it with the physical page number that was stored as the line's tag when the line was filled, and reports hit or miss. On a hit it also returns the selected word.

Only the page-offset bits of the load reach the block. The virtual page number goes to the translation buffer outside it. If the translation buffer reports a miss, the block keeps the page offset and gives no result. It lowers its ready output until a valid translation arrives, and then finishes the held load.

Lines are written through a fill port. In one cycle the fill port supplies the index, every word of the line and the physical page number. The block has no write path for stores and no link to the next memory level.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `resp_valid` is 0. Any load before the first fill completes as a miss.
- R2: The page offset is split as follows. Bits [WOFS_W-1:0] select the word within the line. Bits [WOFS_W+IDX_W-1:WOFS_W] select the line.
- R3: A load completes as a hit when the line is valid and its stored physical page number equals `xlat_ppn`. On a hit, `resp_hit` is 1 and `resp_data` is the selected word.
- R4: A load completes as a miss when the line is invalid or its stored physical page number differs from `xlat_ppn`. On a miss, `resp_hit` is 0.
- R5: A fill with `fill_en` high writes all words of line `fill_idx` in one cycle and stores `fill_ppn` as the line's tag. It also marks the line valid. Word w is taken from `fill_data[w*WORD_W +: WORD_W]`. A later fill of the same line replaces the tag and the data.
- R6: A load is active in a cycle when `req_valid` and `req_ready` are both high, or when a load is being held. An active load with `xlat_valid` high gives `resp_valid` high for exactly one cycle, in the next cycle. No other cycle has `resp_valid` high.
- R7: An active load with `xlat_valid` low gives no result, and `req_ready` is 0 in the next cycle. While `req_ready` is 0, `req_pofs` and `req_valid` are ignored. The held load finishes using its own page offset in the cycle in which `xlat_valid` is high, and `req_ready` returns to 1 in the following cycle.
- R8: When an active load and a fill target the same line in the same cycle, the load sees the new contents: the fill's tag, its data and a valid line.
- R9: `resp_data` is 0 whenever `resp_valid` is 0 or `resp_hit` is 0, and `resp_hit` is 0 whenever `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request |
| req_pofs | input | PGOFS_W | Page-offset bits of the load address |
| req_ready | output | 1 | High when no load is being held |
| xlat_valid | input | 1 | Translation of the active load is available |
| xlat_ppn | input | PPN_W | Physical page number from the translation buffer |
| fill_en | input | 1 | Line fill strobe |
| fill_idx | input | IDX_W | Line written by the fill |
| fill_ppn | input | PPN_W | Physical page number stored as the tag |
| fill_data | input | WORD_W<<WOFS_W | All words of the filled line, word 0 in the low bits |
| resp_valid | output | 1 | Result of a load is present |
| resp_hit | output | 1 | The load hit |
| resp_data | output | WORD_W | Loaded word on a hit, otherwise 0 |

## Verification
The hardest case to reach from the ports is a held load whose line changes while the load waits for its translation. In that case the fill lands on the held line, sometimes in the same cycle that the translation finally arrives. The bench reaches it in two ways. Directed steps hold a load over several cycles with a different offset on the input, and a separate step issues a fill and a load to the same line together. A long random phase then mixes frequent translation misses, fills to random lines and a pool of only four physical page numbers. Because the pool is so small, hits, tag replacements and fill-bypass collisions all occur often. A behavioural model checks every one of these cycles.

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int WORD_W  = 32,
  parameter int WOFS_W  = 2,
  parameter int IDX_W   = 3,
  parameter int PGOFS_W = 5,
  parameter int PPN_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [PGOFS_W-1:0]          req_pofs,
  output logic                        req_ready,
  input  logic                        xlat_valid,
  input  logic [PPN_W-1:0]            xlat_ppn,
  input  logic                        fill_en,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [PPN_W-1:0]            fill_ppn,
  input  logic [(WORD_W<<WOFS_W)-1:0] fill_data,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [WORD_W-1:0]           resp_data
);
  localparam int WORDS = 1 << WOFS_W;
  localparam int LINES = 1 << IDX_W;

  if (IDX_W + WOFS_W > PGOFS_W) begin : g_bad_split
    $error("index and word select must fit in the page offset");
  end

  logic [WORD_W-1:0] data_q [LINES][WORDS];
  logic [PPN_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q;
  logic              pend_q;
  logic [PGOFS_W-1:0] pofs_q;

  logic [PGOFS_W-1:0] ofs;
  logic [IDX_W-1:0]   idx;
  logic [WOFS_W-1:0]  wsel;
  logic               active, byp, lvld, hit;
  logic [PPN_W-1:0]   ltag;
  logic [WORD_W-1:0]  fword, word;

  assign req_ready = !pend_q;
  assign active    = pend_q | req_valid;
  assign ofs       = pend_q ? pofs_q : req_pofs;
  assign idx       = ofs[WOFS_W +: IDX_W];
  assign wsel      = ofs[WOFS_W-1:0];
  assign byp       = fill_en && (fill_idx == idx);

  always_comb begin
    fword = '0;
    for (int w = 0; w < WORDS; w++)
      if (wsel == WOFS_W'(w)) fword = fill_data[w*WORD_W +: WORD_W];
  end

  assign lvld = byp | vld_q[idx];
  assign ltag = byp ? fill_ppn : tag_q[idx];
  assign word = byp ? fword : data_q[idx][wsel];
  assign hit  = lvld && (ltag == xlat_ppn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      pend_q     <= 1'b0;
      pofs_q     <= '0;
    end else if (active && xlat_valid) begin
      resp_valid <= 1'b1;
      resp_hit   <= hit;
      resp_data  <= hit ? word : '0;
      pend_q     <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      if (active) begin
        pend_q <= 1'b1;
        pofs_q <= ofs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (fill_en) vld_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_ppn;
      for (int w = 0; w < WORDS; w++)
        data_q[fill_idx][w] <= fill_data[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              xlat_valid,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [WORD_W-1:0] resp_data
);
  logic act;
  assign act = req_valid || !req_ready;

  a_r6_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (act && xlat_valid) |=> resp_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(act && xlat_valid) |=> !resp_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !xlat_valid) |=> !req_ready);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && xlat_valid) |=> req_ready);

  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_valid || !resp_hit) |-> (resp_data == '0));

  a_r9_quiet_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_hit);
endmodule

bind vipt_cache vipt_cache_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .xlat_valid(xlat_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_data(resp_data)
);

// File: tb/vipt_cache_test.sv
`timescale 1ns/1ps
module vipt_cache_test;
  localparam int WORD_W = 32, WOFS_W = 2, IDX_W = 3, PGOFS_W = 5, PPN_W = 8;
  localparam int WORDS = 1 << WOFS_W, LINES = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, xlat_valid = 0, fill_en = 0;
  logic [PGOFS_W-1:0] req_pofs = '0;
  logic [PPN_W-1:0] xlat_ppn = '0, fill_ppn = '0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [WORD_W*WORDS-1:0] fill_data = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [WORD_W-1:0] resp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vipt_cache uut (.*);

  // behavioural reference
  logic [WORD_W-1:0] m_data [LINES][WORDS];
  logic [PPN_W-1:0]  m_tag [LINES];
  bit m_val [LINES];
  bit pend, e_valid, e_hit, e_ready;
  int pend_ofs;
  logic [WORD_W-1:0] e_data;

  task automatic model_step();
    int o, li, wi;
    bit v;
    logic [PPN_W-1:0] t;
    logic [WORD_W-1:0] d;
    if (!rst_n) begin
      foreach (m_val[i]) m_val[i] = 0;
      pend = 0; e_valid = 0; e_hit = 0; e_data = 0; e_ready = 1;
      return;
    end
    o  = pend ? pend_ofs : int'(req_pofs);
    li = (o / WORDS) % LINES;
    wi = o % WORDS;
    if (fill_en && int'(fill_idx) == li) begin
      v = 1; t = fill_ppn; d = fill_data[wi*WORD_W +: WORD_W];
    end else begin
      v = m_val[li]; t = m_tag[li]; d = m_data[li][wi];
    end
    if ((pend || req_valid) && xlat_valid) begin
      e_valid = 1; e_hit = v && (t == xlat_ppn); e_data = e_hit ? d : 0; pend = 0;
    end else begin
      e_valid = 0; e_hit = 0; e_data = 0;
      if (pend || req_valid) begin pend = 1; pend_ofs = o; end
    end
    e_ready = !pend;
    if (fill_en) begin
      m_val[fill_idx] = 1; m_tag[fill_idx] = fill_ppn;
      for (int w = 0; w < WORDS; w++) m_data[fill_idx][w] = fill_data[w*WORD_W +: WORD_W];
    end
  endtask

  task automatic chk(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (rst_n) begin
      chk("R6 model resp_valid", resp_valid, e_valid);
      chk("R3 R4 model resp_hit", resp_hit, e_hit);
      chk("R3 R9 model resp_data", resp_data, e_data);
      chk("R7 model req_ready", req_ready, e_ready);
    end
  endtask

  task automatic idle();
    req_valid = 0; xlat_valid = 0; fill_en = 0;
  endtask

  task automatic load(int li, int wi, bit xv, logic [PPN_W-1:0] ppn);
    req_valid = 1; req_pofs = PGOFS_W'(li * WORDS + wi);
    xlat_valid = xv; xlat_ppn = ppn;
  endtask

  task automatic fill(int li, logic [PPN_W-1:0] ppn, int base);
    fill_en = 1; fill_idx = IDX_W'(li); fill_ppn = ppn;
    for (int w = 0; w < WORDS; w++) fill_data[w*WORD_W +: WORD_W] = WORD_W'(base + w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no response after reset", resp_valid, 0);

    for (int l = 0; l < LINES; l++) begin
      load(l, 0, 1, 0); tick(); idle();
      chk("R1 empty line misses", {resp_valid, resp_hit}, 2'b10);
    end

    fill(2, 8'h35, 32'h200); tick(); idle();
    load(2, 1, 1, 8'h35); tick(); idle();
    chk("R3 R5 hit valid", {resp_valid, resp_hit}, 2'b11);
    chk("R3 R5 hit data", resp_data, 32'h201);
    load(2, 3, 1, 8'h35); tick(); idle();
    chk("R2 word select", resp_data, 32'h203);
    load(3, 1, 1, 8'h35); tick(); idle();
    chk("R2 line select", {resp_valid, resp_hit}, 2'b10);

    load(2, 1, 1, 8'h36); tick(); idle();
    chk("R4 tag mismatch", {resp_valid, resp_hit}, 2'b10);
    chk("R9 miss data zero", resp_data, 0);

    load(2, 2, 0, 8'h35); tick();
    chk("R7 no result on tlb miss", resp_valid, 0);
    chk("R7 ready drops", req_ready, 0);
    load(3, 0, 0, 8'h00); tick();
    chk("R7 still held", {resp_valid, req_ready}, 2'b00);
    load(3, 0, 1, 8'h35); tick(); idle();
    chk("R7 held offset used", {resp_valid, resp_hit}, 2'b11);
    chk("R7 held offset data", resp_data, 32'h202);
    chk("R7 ready returns", req_ready, 1);
    tick();
    chk("R6 single result cycle", resp_valid, 0);

    fill(5, 8'h11, 32'h500); load(5, 2, 1, 8'h11); tick(); idle();
    chk("R8 same cycle fill hit", {resp_valid, resp_hit}, 2'b11);
    chk("R8 same cycle fill data", resp_data, 32'h502);

    fill(2, 8'h44, 32'h900); tick(); idle();
    load(2, 0, 1, 8'h35); tick(); idle();
    chk("R5 old tag replaced", {resp_valid, resp_hit}, 2'b10);
    load(2, 0, 1, 8'h44); tick(); idle();
    chk("R5 new tag data", resp_data, 32'h900);

    for (int n = 0; n < 3000; n++) begin
      req_valid  = ($urandom % 2) == 0;
      req_pofs   = PGOFS_W'($urandom);
      xlat_valid = ($urandom % 10) < 7;
      xlat_ppn   = PPN_W'($urandom % 4);
      fill_en    = ($urandom % 5) == 0;
      fill_idx   = IDX_W'($urandom);
      fill_ppn   = PPN_W'($urandom % 4);
      for (int w = 0; w < WORDS; w++) fill_data[w*WORD_W +: WORD_W] = $urandom;
      tick();
    end
    idle(); tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule